// File: doc/BRIEF.md
# Handshaked Multi-Cycle Byte ALU

A clocked arithmetic unit for two unsigned byte operands. A requester presents the operands and a 3-bit operation code, then raises `go` and holds it high, with the operands and code unchanged, until it sees `done`. It then drops `go` and reads `result`. Add, bitwise AND and bitwise XOR complete one clock edge after `go` is first sampled. Multiply runs for a fixed number of cycles. Every result is zero-extended to twice the operand width.

A code that names no arithmetic operation is a no-op. The requester raises `go` for a single cycle with such a code, and the unit never answers with `done`. After each completion the unit waits for `go` to be sampled low before it accepts another request, so a requester that is slow to drop `go` cannot trigger a second operation. The last result stays on `result` until the next completion. An active-low asynchronous reset clears the result, clears `done` and abandons any multiply in flight.

Top module: `byte_alu_hs`

## Requirements
- R1: With `op_sel` = 3'b001 (add), `result` becomes the zero-extended sum `op_a + op_b`; for example 0xFF + 0xFF gives 0x01FE.
- R2: With `op_sel` = 3'b010 (AND), `result` becomes the zero-extended `op_a & op_b`. With 3'b011 (XOR), it becomes the zero-extended `op_a ^ op_b`.
- R3: With `op_sel` = 3'b100 (multiply), `result` becomes the unsigned product `op_a * op_b`; for example 0xFF * 0xFF gives 0xFE01, and a zero operand gives 0.
- R4: For add, AND and XOR, `done` is high in the cycle that follows the first clock edge at which the idle unit samples `go` high (a latency of 1).
- R5: For multiply, `done` is high after the MUL_LAT-th clock edge, counting from the first edge at which `go` is sampled high (a latency of 3 with the default value).
- R6: `done` is high for exactly one cycle for each completed operation. While `go` stays high after a completion, `done` does not pulse again and `result` does not change. A new operation starts only after `go` has been sampled low.
- R7: `result` holds its value in every cycle without a completion. Reset drives `result` to 0 and `done` to 0.
- R8: The codes 3'b000, 3'b101, 3'b110 and 3'b111, presented with a one-cycle `go`, produce no `done` and leave `result` unchanged. The unit stays ready, and the next add completes with a latency of 1.
- R9: Asserting reset while a multiply is running abandons it. No `done` follows, `result` reads 0, and the next operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Request; held high until `done` is seen |
| op_a | input | 8 | First operand, unsigned |
| op_b | input | 8 | Second operand, unsigned |
| op_sel | input | 3 | Operation code |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Zero-extended result, held until the next completion |

## Verification
Assertions check four properties on every cycle:
- `done` never lasts two cycles and never re-fires while `go` stays high after a completion.
- `result` only moves in a completion cycle.
- An idle unit that sees a no-op code stays idle.
- The multiply countdown reaches its final step exactly once per launch.

Only the bench's scenarios can show the following:
- the arithmetic values at the extreme operands 0x00 and 0xFF;
- the exact latency of each operation class;
- recovery after a no-op;
- recovery after a reset in the middle of a multiply.

The bench checks these against a behavioural reference model that it compares with the outputs on every clock.

// File: rtl/alu_hs_pkg.sv
package alu_hs_pkg;
   localparam logic [2:0] CODE_NOP = 3'b000;
   localparam logic [2:0] CODE_ADD = 3'b001;
   localparam logic [2:0] CODE_AND = 3'b010;
   localparam logic [2:0] CODE_XOR = 3'b011;
   localparam logic [2:0] CODE_MUL = 3'b100;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_e;
endpackage

// File: rtl/alu_hs_decode.sv
module alu_hs_decode
   import alu_hs_pkg::*;
#(
   parameter int DW   = 8,
   parameter int OPW  = 3
) (
   input  logic [OPW-1:0]  code,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic            is_single,
   output logic            is_mul,
   output logic [2*DW-1:0] single_val
);
   localparam int RW = 2 * DW;

   if (OPW != 3) begin : g_bad_opw
      $error("alu_hs_decode: OPW must be 3");
   end

   logic [RW-1:0] a_ext, b_ext;
   assign a_ext = {{DW{1'b0}}, a};
   assign b_ext = {{DW{1'b0}}, b};

   always_comb begin
      is_single  = 1'b0;
      is_mul     = 1'b0;
      single_val = '0;
      case (code)
         CODE_ADD: begin
            is_single  = 1'b1;
            single_val = a_ext + b_ext;
         end
         CODE_AND: begin
            is_single  = 1'b1;
            single_val = a_ext & b_ext;
         end
         CODE_XOR: begin
            is_single  = 1'b1;
            single_val = a_ext ^ b_ext;
         end
         CODE_MUL: is_mul = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/alu_hs_mul.sv
module alu_hs_mul #(
   parameter int DW  = 8,
   parameter int LAT = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic            last,
   output logic [2*DW-1:0] prod
);
   localparam int RW = 2 * DW;
   localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

   if (LAT < 2) begin : g_bad_lat
      $error("alu_hs_mul: LAT must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("alu_hs_mul: DW must be positive");
   end

   logic [DW-1:0] a_q, b_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         cnt <= '0;
      end else if (launch) begin
         a_q <= a;
         b_q <= b;
         cnt <= CW'(LAT - 1);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == CW'(1));
   assign prod = RW'(a_q) * RW'(b_q);

   // R5
   mul_last_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !last);
endmodule

// File: rtl/alu_hs_ctrl.sv
module alu_hs_ctrl
   import alu_hs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic is_single,
   input  logic is_mul,
   input  logic mul_last,
   output logic launch,
   output logic ld_single,
   output logic ld_mul
);
   seq_state_e st, st_nx;

   always_comb begin
      st_nx     = st;
      launch    = 1'b0;
      ld_single = 1'b0;
      ld_mul    = 1'b0;
      case (st)
         ST_IDLE: begin
            if (go && is_single) begin
               ld_single = 1'b1;
               st_nx     = ST_HOLD;
            end else if (go && is_mul) begin
               launch = 1'b1;
               st_nx  = ST_RUN;
            end
         end
         ST_RUN: begin
            if (mul_last) begin
               ld_mul = 1'b1;
               st_nx  = ST_HOLD;
            end
         end
         ST_HOLD: if (!go) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   // R8
   noop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && go && !is_single && !is_mul) |=> (st == ST_IDLE));
endmodule

// File: rtl/byte_alu_hs.sv
module byte_alu_hs
   import alu_hs_pkg::*;
#(
   parameter int DW      = 8,
   parameter int OPW     = 3,
   parameter int MUL_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DW-1:0]    op_a,
   input  logic [DW-1:0]    op_b,
   input  logic [OPW-1:0]   op_sel,
   output logic             done,
   output logic [2*DW-1:0]  result
);
   localparam int RW = 2 * DW;

   logic          is_single, is_mul, mul_last;
   logic          launch, ld_single, ld_mul;
   logic [RW-1:0] single_val, prod;

   alu_hs_decode #(.DW(DW), .OPW(OPW)) u_dec (
      .code(op_sel), .a(op_a), .b(op_b),
      .is_single(is_single), .is_mul(is_mul), .single_val(single_val)
   );

   alu_hs_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .a(op_a), .b(op_b), .last(mul_last), .prod(prod)
   );

   alu_hs_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go),
      .is_single(is_single), .is_mul(is_mul), .mul_last(mul_last),
      .launch(launch), .ld_single(ld_single), .ld_mul(ld_mul)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= ld_single | ld_mul;
         if (ld_single)   result <= single_val;
         else if (ld_mul) result <= prod;
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   no_repulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && go) |=> !done);
   // R7
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   // R4
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(go));
endmodule

// File: tb/tb_byte_alu_hs.sv
module tb_byte_alu_hs;
   localparam int DW  = 8;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [7:0]  a = '0, b = '0;
   logic [2:0]  code = '0;
   logic        done;
   logic [15:0] res;

   byte_alu_hs #(.DW(DW), .OPW(3), .MUL_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .go(go), .op_a(a), .op_b(b),
      .op_sel(code), .done(done), .result(res)
   );

   always #5 clk = ~clk;

   int    n_cmp = 0, n_bad = 0;
   string phase = "R7";
   bit    live = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ref_val(input logic [7:0] x, input logic [7:0] y, input logic [2:0] c);
      case (c)
         3'b001:  return int'(x) + int'(y);
         3'b010:  return int'(x & y);
         3'b011:  return int'(x ^ y);
         3'b100:  return int'(x) * int'(y);
         default: return -1;
      endcase
   endfunction

   // behavioural reference model
   int          m_cnt;
   bit          m_hold, m_done;
   logic [15:0] m_res, m_pend;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_hold = 0; m_done = 0; m_res = 0; m_pend = 0;
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1; m_res = m_pend; m_hold = 1;
            end
         end else if (m_hold) begin
            if (!go) m_hold = 0;
         end else if (go) begin
            if (code == 3'b100) begin
               m_pend = 16'(ref_val(a, b, code));
               m_cnt  = LAT - 1;
            end else if (ref_val(a, b, code) >= 0) begin
               m_res = 16'(ref_val(a, b, code)); m_done = 1; m_hold = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (live && rst_n) begin
         chk(done === m_done, {phase, " done vs model"}, int'(done), int'(m_done));
         chk(res === m_res, {phase, " result vs model"}, int'(res), int'(m_res));
      end
   end

   task automatic run_op(input logic [7:0] ia, input logic [7:0] ib, input logic [2:0] c,
                         input int lat, input int extra, input string tag);
      int n = 0;
      logic [15:0] got;
      @(negedge clk);
      a = ia; b = ib; code = c; go = 1'b1; phase = tag;
      forever begin
         @(negedge clk);
         n++;
         if (done === 1'b1 || n > 12) break;
      end
      chk(n == lat, {tag, " latency"}, n, lat);
      chk(res == 16'(ref_val(ia, ib, c)), {tag, " value"}, int'(res), ref_val(ia, ib, c));
      got = res;
      for (int k = 0; k < extra; k++) begin
         @(negedge clk);
         chk(done == 1'b0, "R6 no re-pulse with go held", int'(done), 0);
         chk(res == got, "R6 result steady with go held", int'(res), int'(got));
      end
      go = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] keep;
      repeat (2) @(negedge clk);
      chk(done == 1'b0, "R7 reset done", int'(done), 0);
      chk(res == 16'h0, "R7 reset result", int'(res), 0);
      rst_n = 1'b1; live = 1'b1;

      run_op(8'h12, 8'h34, 3'b001, 1, 0, "R1 R4 add");
      run_op(8'hFF, 8'hFF, 3'b001, 1, 0, "R1 add max");
      run_op(8'h00, 8'hFF, 3'b001, 1, 0, "R1 add zero");
      run_op(8'hA5, 8'h0F, 3'b010, 1, 0, "R2 R4 and");
      run_op(8'h00, 8'hFF, 3'b010, 1, 0, "R2 and zero");
      run_op(8'hFF, 8'h0F, 3'b011, 1, 0, "R2 xor");
      run_op(8'hFF, 8'hFF, 3'b011, 1, 0, "R2 xor ones");
      run_op(8'h0F, 8'h11, 3'b100, LAT, 0, "R3 R5 mul");
      run_op(8'hFF, 8'hFF, 3'b100, LAT, 0, "R3 mul max");
      run_op(8'h00, 8'hFF, 3'b100, LAT, 0, "R3 mul zero");
      run_op(8'hFF, 8'h01, 3'b100, LAT, 0, "R3 mul one");

      run_op(8'h21, 8'h43, 3'b001, 1, 4, "R6 add held");
      run_op(8'h07, 8'h09, 3'b100, LAT, 4, "R6 mul held");
      run_op(8'h01, 8'h02, 3'b011, 1, 0, "R6 back to back");

      for (int i = 0; i < 4; i++) begin
         logic [2:0] nc;
         nc = (i == 0) ? 3'b000 : 3'(4 + i);
         keep = res;
         @(negedge clk);
         a = 8'h03; b = 8'h04; code = nc; go = 1'b1; phase = "R8 no-op";
         @(negedge clk);
         go = 1'b0;
         for (int k = 0; k < 3; k++) begin
            chk(done == 1'b0, "R8 no done for no-op", int'(done), 0);
            chk(res == keep, "R8 result kept after no-op", int'(res), int'(keep));
            @(negedge clk);
         end
      end
      run_op(8'h05, 8'h06, 3'b001, 1, 0, "R8 ready after no-op");

      @(negedge clk);
      a = 8'hFF; b = 8'hFF; code = 3'b100; go = 1'b1; phase = "R9";
      @(negedge clk);
      rst_n = 1'b0; go = 1'b0;
      #1;
      chk(res == 16'h0, "R9 result cleared mid-multiply", int'(res), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < LAT + 1; k++) begin
         @(negedge clk);
         chk(done == 1'b0, "R9 abandoned multiply gives no done", int'(done), 0);
      end
      run_op(8'h0C, 8'h0D, 3'b100, LAT, 0, "R9 multiply after reset");

      for (int i = 0; i < 40; i++) begin
         logic [2:0] c;
         logic [7:0] x, y;
         c = 3'(1 + ($urandom % 4));
         x = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
         y = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
         run_op(x, y, c, (c == 3'b100) ? LAT : 1, int'($urandom % 3),
                "R1 R2 R3 random");
      end

      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule